// File: doc/BRIEF.md
# Set-Associative Tag Array with March Self-Test

This block keeps the tag memories of an N-way cache, one synchronous memory per way. A client sends handshaked requests of four kinds: lookup, store, flush and self-test. Each request gets one handshaked response. The response carries a hit flag, a one-hot way vector, a dirty flag and a tag. Each tag word holds a valid bit, a dirty bit and the tag itself. A per-way scratch-pad mask removes ways from lookups and from victim choice. The mask is written through a small configuration port and can be read back.

After reset the block runs a March X test on every way in parallel. Each read during the test is checked by the same per-way comparators that detect hits in normal use. When the test ends, every tag word is zero. A way that failed has its bit set in the error vector and stays masked out. Every way that passed is put into cache use, whatever mask was written while the test was running. No request is accepted until the test is done.

The control machine has three states. CTL_SELFTEST lasts until the march completes. CTL_IDLE accepts one request and reads every way at its index. CTL_COMPARE presents the response and returns to CTL_IDLE on the response handshake. The march sequencer steps through these states in order:
- MX_FILL0: write 0 upward.
- MX_UP_R0W1: read 0, then write 1, going upward.
- MX_DN_R1W0: read 1, then write 0, going downward.
- MX_CHK0: read 0.
- MX_SETTLE: the error vector settles.
- MX_FINISH: the test has ended.

Top module: `way_tag_array`

## Requirements
- R1: After reset `req_ready_o` and `bist_done_o` are low while the self-test runs. The test takes at least 4×LINES cycles. Afterwards `bist_done_o` stays high, `bist_err_o` is zero for fault-free memories, and `req_ready_o` rises.
- R2: When the self-test ends, every tag word is zero: valid clear, dirty clear, tag zero.
- R3: When the self-test ends, `spm_o` is loaded with the error vector. This overrides any mask write made during the test. Mask writes (`spm_we_i`) take effect only while the block is idle.
- R4: A request accepted on a rising edge has its response valid after that edge. This holds for a hit, a store, a flush or a self-test-coded request.
- R5: A lookup compares only the ways whose `spm_o` bit is 0. On a hit, `rsp_hit_o`=1, `rsp_way_o` is the one-hot matching way, `rsp_dirty_o` is its dirty bit and `rsp_evict_tag_o` is its tag. If every way is masked, a lookup answers a miss with `rsp_way_o`=0.
- R6: On a lookup miss, a one-hot rotator advances every cycle. It stops on an unmasked invalid way if one exists at that index, and otherwise on any unmasked way. The response and the rotator are held unchanged until `rsp_ready_i` is seen.
- R7: A miss returns the chosen victim's dirty bit (valid and dirty) and its stored tag.
- R8: A store (`req_mode_i`=01) writes valid=1, the tag, and dirty=`req_write_i` into the way given by `req_way_i`. It responds with hit=0, way=`req_way_i`, dirty=0, tag=0.
- R9: A flush (`req_mode_i`=10) reports the named way's dirty bit (valid and dirty) and its tag, and then zeroes that word. Other ways are untouched.
- R10: A request coded as self-test (`req_mode_i`=11) changes no tag word. It responds with all-zero fields. Lookup is coded 00.
- R11: `req_ready_o` is never high while `rsp_valid_o` is high, so at most one request is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset, starts the self-test |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request ready |
| req_mode_i | input | 2 | 00 lookup, 01 store, 10 flush, 11 self-test |
| req_index_i | input | $clog2(LINES) | Line index |
| req_tag_i | input | TAG_W | Tag to compare or store |
| req_way_i | input | WAYS | One-hot way for store and flush |
| req_write_i | input | 1 | Store comes from a write (sets dirty) |
| rsp_valid_o | output | 1 | Response valid |
| rsp_ready_i | input | 1 | Response ready |
| rsp_hit_o | output | 1 | Lookup hit |
| rsp_way_o | output | WAYS | One-hot way of the hit, victim or target |
| rsp_dirty_o | output | 1 | Line is valid and dirty |
| rsp_evict_tag_o | output | TAG_W | Tag stored in the reported line |
| spm_we_i | input | 1 | Scratch-pad mask write strobe |
| spm_wdata_i | input | WAYS | New scratch-pad mask |
| spm_o | output | WAYS | Current scratch-pad mask (1 = excluded) |
| bist_done_o | output | 1 | Self-test finished |
| bist_err_o | output | WAYS | Per-way self-test failure |

## Verification
The hardest state to reach from the ports is a miss whose victim can be predicted. The rotator runs freely, so its position at any moment cannot be known from outside. The stimulus removes this uncertainty with the scratch-pad mask. It leaves exactly one unmasked way, or one unmasked invalid way, at the index under test. It first fills lines with stores that set chosen dirty bits and tags, so the victim's dirty bit and old tag become known values. For a miss with several candidates, the check is only that the way is one-hot and does not move while the response is held back.

// File: rtl/tagarr_pkg.sv
package tagarr_pkg;

    typedef enum logic [1:0] {
        REQ_LOOKUP = 2'b00,
        REQ_STORE  = 2'b01,
        REQ_FLUSH  = 2'b10,
        REQ_BIST   = 2'b11
    } req_kind_e;

    typedef enum logic [1:0] {
        CTL_SELFTEST,
        CTL_IDLE,
        CTL_COMPARE
    } ctl_state_e;

    typedef enum logic [2:0] {
        MX_FILL0,
        MX_UP_R0W1,
        MX_DN_R1W0,
        MX_CHK0,
        MX_SETTLE,
        MX_FINISH
    } march_state_e;

endpackage

// File: rtl/tagarr_ram.sv
module tagarr_ram #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned WIDTH = 10
) (
    input  logic                     clk_i,
    input  logic                     en_i,
    input  logic                     we_i,
    input  logic [$clog2(DEPTH)-1:0] addr_i,
    input  logic [WIDTH-1:0]         wdata_i,
    output logic [WIDTH-1:0]         rdata_o
);
    logic [WIDTH-1:0] mem_q [DEPTH];

    // single port: a write leaves the read register untouched
    always_ff @(posedge clk_i) begin
        if (en_i) begin
            if (we_i) mem_q[addr_i] <= wdata_i;
            else      rdata_o       <= mem_q[addr_i];
        end
    end
endmodule

// File: rtl/tagarr_march.sv
module tagarr_march
    import tagarr_pkg::*;
#(
    parameter int unsigned LINES  = 16,
    parameter int unsigned WAYS   = 4,
    parameter int unsigned WORD_W = 10
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic [WAYS-1:0]          ok_i,
    output logic                     en_o,
    output logic                     we_o,
    output logic [$clog2(LINES)-1:0] addr_o,
    output logic [WORD_W-1:0]        wdata_o,
    output logic [WORD_W-1:0]        exp_o,
    output logic                     chk_o,
    output logic                     finish_o,
    output logic                     done_o,
    output logic [WAYS-1:0]          err_o
);
    localparam int unsigned IDX_W = $clog2(LINES);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(LINES - 1);

    march_state_e      state_q, state_d;
    logic [IDX_W-1:0]  addr_q, addr_d;
    logic              phase_q, phase_d;
    logic [WAYS-1:0]   err_q, err_d;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= MX_FILL0;
            addr_q  <= '0;
            phase_q <= 1'b0;
            err_q   <= '0;
        end else begin
            state_q <= state_d;
            addr_q  <= addr_d;
            phase_q <= phase_d;
            err_q   <= err_d;
        end
    end

    // phase 0 issues the read, phase 1 compares (and writes the inverse)
    always_comb begin
        state_d  = state_q;
        addr_d   = addr_q;
        phase_d  = phase_q;
        en_o     = 1'b0;
        we_o     = 1'b0;
        wdata_o  = '0;
        exp_o    = '0;
        chk_o    = 1'b0;
        finish_o = 1'b0;
        unique case (state_q)
            MX_FILL0: begin
                en_o   = 1'b1;
                we_o   = 1'b1;
                addr_d = addr_q + 1'b1;
                if (addr_q == LAST) begin
                    state_d = MX_UP_R0W1;
                    addr_d  = '0;
                end
            end
            MX_UP_R0W1: begin
                en_o    = 1'b1;
                phase_d = ~phase_q;
                if (phase_q) begin
                    chk_o   = 1'b1;
                    we_o    = 1'b1;
                    wdata_o = '1;
                    addr_d  = addr_q + 1'b1;
                    if (addr_q == LAST) begin
                        state_d = MX_DN_R1W0;
                        addr_d  = LAST;
                    end
                end
            end
            MX_DN_R1W0: begin
                en_o    = 1'b1;
                phase_d = ~phase_q;
                if (!phase_q) begin
                    exp_o = '1;
                end else begin
                    chk_o  = 1'b1;
                    we_o   = 1'b1;
                    addr_d = addr_q - 1'b1;
                    if (addr_q == '0) begin
                        state_d = MX_CHK0;
                        addr_d  = '0;
                    end
                end
            end
            MX_CHK0: begin
                phase_d = ~phase_q;
                if (!phase_q) begin
                    en_o = 1'b1;
                end else begin
                    chk_o  = 1'b1;
                    addr_d = addr_q + 1'b1;
                    if (addr_q == LAST) state_d = MX_SETTLE;
                end
            end
            MX_SETTLE: begin
                finish_o = 1'b1;
                state_d  = MX_FINISH;
            end
            MX_FINISH: ;
            default: state_d = MX_FINISH;
        endcase
    end

    assign err_d  = chk_o ? (err_q | ~ok_i) : err_q;
    assign addr_o = addr_q;
    assign done_o = (state_q == MX_FINISH);
    assign err_o  = err_q;
endmodule

// File: rtl/tagarr_victim.sv
module tagarr_victim #(
    parameter int unsigned WAYS = 4
) (
    input  logic            clk_i,
    input  logic            rst_ni,
    input  logic            hold_i,
    output logic [WAYS-1:0] rot_o
);
    logic [WAYS-1:0] rot_q, rot_nx;

    if (WAYS > 1) begin : g_rot
        assign rot_nx = {rot_q[WAYS-2:0], rot_q[WAYS-1]};
    end else begin : g_one
        assign rot_nx = rot_q;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      rot_q <= WAYS'(1);
        else if (!hold_i) rot_q <= rot_nx;
    end

    assign rot_o = rot_q;
endmodule

// File: rtl/way_tag_array.sv
module way_tag_array
    import tagarr_pkg::*;
#(
    parameter int unsigned WAYS  = 4,
    parameter int unsigned LINES = 16,
    parameter int unsigned TAG_W = 8
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic                     req_valid_i,
    output logic                     req_ready_o,
    input  logic [1:0]               req_mode_i,
    input  logic [$clog2(LINES)-1:0] req_index_i,
    input  logic [TAG_W-1:0]         req_tag_i,
    input  logic [WAYS-1:0]          req_way_i,
    input  logic                     req_write_i,
    output logic                     rsp_valid_o,
    input  logic                     rsp_ready_i,
    output logic                     rsp_hit_o,
    output logic [WAYS-1:0]          rsp_way_o,
    output logic                     rsp_dirty_o,
    output logic [TAG_W-1:0]         rsp_evict_tag_o,
    input  logic                     spm_we_i,
    input  logic [WAYS-1:0]          spm_wdata_i,
    output logic [WAYS-1:0]          spm_o,
    output logic                     bist_done_o,
    output logic [WAYS-1:0]          bist_err_o
);
    localparam int unsigned IDX_W  = $clog2(LINES);
    localparam int unsigned WORD_W = TAG_W + 2;
    localparam int unsigned VBIT   = TAG_W + 1;
    localparam int unsigned DBIT   = TAG_W;

    ctl_state_e       state_q, state_d;
    req_kind_e        kind_q;
    logic [IDX_W-1:0] idx_q;
    logic [TAG_W-1:0] tag_q;
    logic [WAYS-1:0]  way_q;
    logic             expv_q, expd_q;
    logic [WAYS-1:0]  spm_q;

    logic              m_en, m_we, m_chk, m_finish, m_done;
    logic [IDX_W-1:0]  m_addr;
    logic [WORD_W-1:0] m_wdata, m_exp;
    logic [WAYS-1:0]   m_err;

    logic              accept, rsp_fire;
    logic              rd_all;
    logic [WAYS-1:0]   wr_vec;
    logic [IDX_W-1:0]  ram_addr;
    logic [WORD_W-1:0] ram_wdata;

    logic [WORD_W-1:0] rd_word [WAYS];
    logic [WAYS-1:0]   rd_valid, rd_dirty, tag_eq, bist_ok;
    logic [WAYS-1:0]   hit_vec, act_vec, free_vec, cand_vec, rot;
    logic              on_cand, seek_hold;

    // ---------------- self-test sequencer ----------------
    tagarr_march #(.LINES(LINES), .WAYS(WAYS), .WORD_W(WORD_W)) u_march (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .ok_i     (bist_ok),
        .en_o     (m_en),
        .we_o     (m_we),
        .addr_o   (m_addr),
        .wdata_o  (m_wdata),
        .exp_o    (m_exp),
        .chk_o    (m_chk),
        .finish_o (m_finish),
        .done_o   (m_done),
        .err_o    (m_err)
    );

    // ---------------- per-way memory and comparator ----------------
    for (genvar w = 0; w < WAYS; w++) begin : g_way
        tagarr_ram #(.DEPTH(LINES), .WIDTH(WORD_W)) u_ram (
            .clk_i   (clk_i),
            .en_i    (rd_all | wr_vec[w]),
            .we_i    (wr_vec[w]),
            .addr_i  (ram_addr),
            .wdata_i (ram_wdata),
            .rdata_o (rd_word[w])
        );
        assign rd_valid[w] = rd_word[w][VBIT];
        assign rd_dirty[w] = rd_word[w][DBIT];
        // one comparator per way, shared by lookup and self-test
        assign tag_eq[w]   = (rd_word[w][TAG_W-1:0] == tag_q);
        assign bist_ok[w]  = tag_eq[w] && (rd_valid[w] == expv_q) && (rd_dirty[w] == expd_q);
    end

    assign hit_vec  = tag_eq & rd_valid & ~spm_q;
    assign act_vec  = ~spm_q;
    assign free_vec = act_vec & ~rd_valid;
    assign cand_vec = (|free_vec) ? free_vec : act_vec;
    assign on_cand  = |(rot & cand_vec);

    assign seek_hold = (state_q == CTL_COMPARE) && (kind_q == REQ_LOOKUP)
                     && !(|hit_vec) && on_cand;

    tagarr_victim #(.WAYS(WAYS)) u_victim (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .hold_i (seek_hold),
        .rot_o  (rot)
    );

    // ---------------- state register ----------------
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= CTL_SELFTEST;
            kind_q  <= REQ_LOOKUP;
            idx_q   <= '0;
            tag_q   <= '0;
            way_q   <= '0;
            expv_q  <= 1'b0;
            expd_q  <= 1'b0;
            spm_q   <= '1;
        end else begin
            state_q <= state_d;
            if (state_q == CTL_SELFTEST && m_en && !m_we) begin
                tag_q  <= m_exp[TAG_W-1:0];
                expv_q <= m_exp[VBIT];
                expd_q <= m_exp[DBIT];
            end
            if (accept) begin
                kind_q <= req_kind_e'(req_mode_i);
                idx_q  <= req_index_i;
                tag_q  <= req_tag_i;
                way_q  <= req_way_i;
            end
            if (m_finish)
                spm_q <= m_err;
            else if (spm_we_i && state_q == CTL_IDLE)
                spm_q <= spm_wdata_i;
        end
    end

    // ---------------- next state and outputs ----------------
    always_comb begin
        state_d         = state_q;
        req_ready_o     = 1'b0;
        rsp_valid_o     = 1'b0;
        rsp_hit_o       = 1'b0;
        rsp_way_o       = '0;
        rsp_dirty_o     = 1'b0;
        rsp_evict_tag_o = '0;
        rd_all          = 1'b0;
        wr_vec          = '0;
        ram_addr        = idx_q;
        ram_wdata       = '0;
        accept          = 1'b0;
        rsp_fire        = 1'b0;
        unique case (state_q)
            CTL_SELFTEST: begin
                ram_addr  = m_addr;
                ram_wdata = m_wdata;
                rd_all    = m_en && !m_we;
                wr_vec    = (m_en && m_we) ? '1 : '0;
                if (m_done) state_d = CTL_IDLE;
            end
            CTL_IDLE: begin
                req_ready_o = 1'b1;
                accept      = req_valid_i;
                ram_addr    = req_index_i;
                if (accept) begin
                    rd_all  = 1'b1;
                    state_d = CTL_COMPARE;
                    if (req_kind_e'(req_mode_i) == REQ_STORE) begin
                        wr_vec    = req_way_i;
                        ram_wdata = {1'b1, req_write_i, req_tag_i};
                    end
                end
            end
            CTL_COMPARE: begin
                unique case (kind_q)
                    REQ_LOOKUP: begin
                        if (|hit_vec) begin
                            rsp_valid_o = 1'b1;
                            rsp_hit_o   = 1'b1;
                            rsp_way_o   = hit_vec;
                            rsp_dirty_o = |(hit_vec & rd_dirty);
                            rsp_evict_tag_o = tag_q;
                        end else if (!(|act_vec)) begin
                            rsp_valid_o = 1'b1;
                        end else if (on_cand) begin
                            rsp_valid_o = 1'b1;
                            rsp_way_o   = rot;
                            rsp_dirty_o = |(rot & rd_valid & rd_dirty);
                            for (int w = 0; w < WAYS; w++)
                                if (rot[w]) rsp_evict_tag_o = rd_word[w][TAG_W-1:0];
                        end
                    end
                    REQ_STORE: begin
                        rsp_valid_o = 1'b1;
                        rsp_way_o   = way_q;
                    end
                    REQ_FLUSH: begin
                        rsp_valid_o = 1'b1;
                        rsp_way_o   = way_q;
                        rsp_dirty_o = |(way_q & rd_valid & rd_dirty);
                        for (int w = 0; w < WAYS; w++)
                            if (way_q[w]) rsp_evict_tag_o = rd_word[w][TAG_W-1:0];
                    end
                    REQ_BIST: begin
                        rsp_valid_o = 1'b1;
                    end
                    default: rsp_valid_o = 1'b1;
                endcase
                rsp_fire = rsp_valid_o && rsp_ready_i;
                if (rsp_fire) begin
                    state_d = CTL_IDLE;
                    if (kind_q == REQ_FLUSH) begin
                        wr_vec    = way_q;
                        ram_wdata = '0;
                    end
                end
            end
            default: state_d = CTL_IDLE;
        endcase
    end

    assign spm_o       = spm_q;
    assign bist_done_o = m_done;
    assign bist_err_o  = m_err;
endmodule

// File: rtl/way_tag_array_chk.sv
module way_tag_array_chk #(
    parameter int unsigned WAYS  = 4,
    parameter int unsigned TAG_W = 8
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             req_ready_o,
    input logic             rsp_valid_o,
    input logic             rsp_ready_i,
    input logic             rsp_hit_o,
    input logic [WAYS-1:0]  rsp_way_o,
    input logic             rsp_dirty_o,
    input logic [TAG_W-1:0] rsp_evict_tag_o,
    input logic [WAYS-1:0]  spm_o,
    input logic             bist_done_o,
    input logic [WAYS-1:0]  bist_err_o
);
    assert_stall_in_test_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !bist_done_o |-> !req_ready_o);

    assert_done_sticky_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bist_done_o |=> bist_done_o);

    assert_cfg_at_done_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(bist_done_o) |-> (spm_o == bist_err_o));

    assert_hit_onehot_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rsp_valid_o && rsp_hit_o) |-> ($countones(rsp_way_o) == 1));

    assert_hit_unmasked_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rsp_valid_o && rsp_hit_o) |-> ((rsp_way_o & spm_o) == '0));

    assert_rsp_held_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rsp_valid_o && !rsp_ready_i) |=> (rsp_valid_o && $stable(rsp_way_o)
            && $stable(rsp_hit_o) && $stable(rsp_dirty_o) && $stable(rsp_evict_tag_o)));

    assert_single_flight_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_ready_o |-> !rsp_valid_o);
endmodule

bind way_tag_array way_tag_array_chk #(.WAYS(WAYS), .TAG_W(TAG_W)) u_chk (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .req_ready_o     (req_ready_o),
    .rsp_valid_o     (rsp_valid_o),
    .rsp_ready_i     (rsp_ready_i),
    .rsp_hit_o       (rsp_hit_o),
    .rsp_way_o       (rsp_way_o),
    .rsp_dirty_o     (rsp_dirty_o),
    .rsp_evict_tag_o (rsp_evict_tag_o),
    .spm_o           (spm_o),
    .bist_done_o     (bist_done_o),
    .bist_err_o      (bist_err_o)
);

// File: tb/sim_way_tag_array.sv
module sim_way_tag_array;
    localparam int CLK_PERIOD = 10;
    localparam int NW = 4;
    localparam int NL = 16;
    localparam int TW = 8;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_ready, req_write = 1'b0;
    logic [1:0] req_mode = 2'b00;
    logic [3:0] req_index = '0;
    logic [TW-1:0] req_tag = '0;
    logic [NW-1:0] req_way = '0;
    logic rsp_valid, rsp_ready = 1'b0, rsp_hit, rsp_dirty;
    logic [NW-1:0] rsp_way, spm, bist_err;
    logic [TW-1:0] rsp_tag;
    logic spm_we = 1'b0, bist_done;
    logic [NW-1:0] spm_wdata = '0;

    int checks = 0, errors = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    way_tag_array #(.WAYS(NW), .LINES(NL), .TAG_W(TW)) u0 (
        .clk_i(clk), .rst_ni(rst_n),
        .req_valid_i(req_valid), .req_ready_o(req_ready), .req_mode_i(req_mode),
        .req_index_i(req_index), .req_tag_i(req_tag), .req_way_i(req_way),
        .req_write_i(req_write),
        .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready), .rsp_hit_o(rsp_hit),
        .rsp_way_o(rsp_way), .rsp_dirty_o(rsp_dirty), .rsp_evict_tag_o(rsp_tag),
        .spm_we_i(spm_we), .spm_wdata_i(spm_wdata), .spm_o(spm),
        .bist_done_o(bist_done), .bist_err_o(bist_err)
    );

    typedef struct packed {
        logic [3:0]    msk;
        logic [1:0]    mode;
        logic [3:0]    idx;
        logic [TW-1:0] tag;
        logic [NW-1:0] way;
        logic          wr;
        logic          ehit;
        logic [NW-1:0] eway;
        logic          edirty;
        logic [TW-1:0] etag;
        logic [3:0]    rq;
    } row_t;

    // mode: 00 lookup, 01 store, 10 flush, 11 self-test coded
    localparam row_t TBL [18] = '{
        '{4'b0000, 2'b01, 4'd3, 8'hA5, 4'b0010, 1'b1, 1'b0, 4'b0010, 1'b0, 8'h00, 4'd8},  // R8
        '{4'b0000, 2'b00, 4'd3, 8'hA5, 4'b0000, 1'b0, 1'b1, 4'b0010, 1'b1, 8'hA5, 4'd5},  // R5
        '{4'b1110, 2'b00, 4'd3, 8'hA5, 4'b0000, 1'b0, 1'b0, 4'b0001, 1'b0, 8'h00, 4'd5},  // R5 masked hit
        '{4'b0000, 2'b01, 4'd3, 8'h3C, 4'b0001, 1'b0, 1'b0, 4'b0001, 1'b0, 8'h00, 4'd8},  // R8
        '{4'b0000, 2'b00, 4'd3, 8'h3C, 4'b0000, 1'b0, 1'b1, 4'b0001, 1'b0, 8'h3C, 4'd8},  // R8 clean
        '{4'b0000, 2'b01, 4'd7, 8'h11, 4'b0001, 1'b1, 1'b0, 4'b0001, 1'b0, 8'h00, 4'd8},  // R8
        '{4'b0000, 2'b01, 4'd7, 8'h22, 4'b0010, 1'b0, 1'b0, 4'b0010, 1'b0, 8'h00, 4'd8},  // R8
        '{4'b1110, 2'b00, 4'd7, 8'h33, 4'b0000, 1'b0, 1'b0, 4'b0001, 1'b1, 8'h11, 4'd7},  // R7 dirty victim
        '{4'b1101, 2'b00, 4'd7, 8'h33, 4'b0000, 1'b0, 1'b0, 4'b0010, 1'b0, 8'h22, 4'd7},  // R7 clean victim
        '{4'b0000, 2'b10, 4'd7, 8'h00, 4'b0001, 1'b0, 1'b0, 4'b0001, 1'b1, 8'h11, 4'd9},  // R9
        '{4'b1110, 2'b00, 4'd7, 8'h11, 4'b0000, 1'b0, 1'b0, 4'b0001, 1'b0, 8'h00, 4'd9},  // R9 zeroed
        '{4'b0000, 2'b10, 4'd7, 8'h00, 4'b0001, 1'b0, 1'b0, 4'b0001, 1'b0, 8'h00, 4'd9},  // R9
        '{4'b0000, 2'b11, 4'd3, 8'h3C, 4'b0001, 1'b1, 1'b0, 4'b0000, 1'b0, 8'h00, 4'd10}, // R10
        '{4'b0000, 2'b00, 4'd3, 8'h3C, 4'b0000, 1'b0, 1'b1, 4'b0001, 1'b0, 8'h3C, 4'd10}, // R10 untouched
        '{4'b1111, 2'b00, 4'd3, 8'h3C, 4'b0000, 1'b0, 1'b0, 4'b0000, 1'b0, 8'h00, 4'd5},  // R5 all masked
        '{4'b1100, 2'b01, 4'd9, 8'h01, 4'b0001, 1'b0, 1'b0, 4'b0001, 1'b0, 8'h00, 4'd8},  // R8
        '{4'b1100, 2'b00, 4'd9, 8'h77, 4'b0000, 1'b0, 1'b0, 4'b0010, 1'b0, 8'h00, 4'd6},  // R6 prefers empty
        '{4'b0000, 2'b00, 4'd7, 8'h22, 4'b0000, 1'b0, 1'b1, 4'b0010, 1'b0, 8'h22, 4'd9}   // R9 other way kept
    };

    task automatic check(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic set_mask(input logic [NW-1:0] m);
        spm_we = 1'b1;
        spm_wdata = m;
        @(negedge clk);
        spm_we = 1'b0;
    endtask

    task automatic issue(input logic [1:0] mode, input logic [3:0] idx, input logic [TW-1:0] tag,
                         input logic [NW-1:0] way, input logic wr, output int lat);
        req_mode = mode; req_index = idx; req_tag = tag; req_way = way; req_write = wr;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 0;
        while (!rsp_valid && lat < 20) begin
            @(negedge clk);
            lat++;
        end
    endtask

    task automatic consume();
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        int lat;
        int cyc;
        logic [NW-1:0] first_way;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: stalled during test
        check(req_ready == 1'b0 && bist_done == 1'b0, "R1 reset stall", {req_ready, bist_done}, 0);
        // R3: this mask write lands during the test and must be overridden
        set_mask(4'b1111);
        cyc = 2;
        while (!bist_done && cyc < 5000) begin
            @(negedge clk);
            cyc++;
        end
        check(cyc >= 4*NL, "R1 test length", cyc, 4*NL);
        check(bist_err == '0, "R1 error vector", bist_err, 0);
        check(spm == '0, "R3 mask after test", spm, 0);
        @(negedge clk);
        check(req_ready == 1'b1 && bist_done == 1'b1, "R1 ready after test", {req_ready, bist_done}, 2'b11);

        // R2: every word zero after the test (single unmasked way exposes it)
        set_mask(4'b1011);
        issue(2'b00, 4'd12, 8'h00, '0, 1'b0, lat);
        check({rsp_hit, rsp_way, rsp_dirty, rsp_tag} == {1'b0, 4'b0100, 1'b0, 8'h00},
              "R2 cleared word", {rsp_hit, rsp_way, rsp_dirty, rsp_tag}, {1'b0, 4'b0100, 1'b0, 8'h00});
        consume();

        for (int i = 0; i < 18; i++) begin
            set_mask(TBL[i].msk);
            issue(TBL[i].mode, TBL[i].idx, TBL[i].tag, TBL[i].way, TBL[i].wr, lat);
            check({rsp_valid, rsp_hit, rsp_way, rsp_dirty, rsp_tag} ==
                  {1'b1, TBL[i].ehit, TBL[i].eway, TBL[i].edirty, TBL[i].etag},
                  $sformatf("R%0d row %0d", TBL[i].rq, i),
                  {rsp_valid, rsp_hit, rsp_way, rsp_dirty, rsp_tag},
                  {1'b1, TBL[i].ehit, TBL[i].eway, TBL[i].edirty, TBL[i].etag});
            // R11: no new request taken while answering
            check(req_ready == 1'b0, "R11 ready low with response", req_ready, 0);
            // R4: fixed one-edge latency except a searching miss
            if (TBL[i].ehit || TBL[i].mode != 2'b00)
                check(lat == 0, $sformatf("R4 latency row %0d", i), lat, 0);
            consume();
        end

        // R6: multi-candidate miss holds its way while the response waits
        set_mask(4'b0000);
        issue(2'b00, 4'd5, 8'h00, '0, 1'b0, lat);
        first_way = rsp_way;
        check($countones(rsp_way) == 1 && !rsp_hit, "R6 one-hot victim", rsp_way, 0);
        repeat (4) @(negedge clk);
        check(rsp_valid && rsp_way == first_way, "R6 victim held", rsp_way, first_way);
        consume();
        check(rsp_valid == 1'b0 && req_ready == 1'b1, "R11 idle after handshake",
              {rsp_valid, req_ready}, 2'b01);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule